// File: doc/BRIEF.md
# Quad SPI Flash Mailbox Read Sequencer

This block sits on the host side of a mailbox that carries 32-bit command and response packets over a pair of streaming ports with valid, ready, start-of-packet and end-of-packet. A single request made of a start strobe, a byte address, a word count and a chip index becomes a fixed transaction of four mailbox commands. The block claims exclusive flash access, selects the flash device, reads the requested words and releases access.

Every response header is checked for a matching transaction ID and a usable result code. The read payload is passed straight to a user output stream. When the transaction ends, the block pulses done and holds an error flag together with the error code it captured. Requests that cannot succeed are refused locally, before any traffic reaches the mailbox. Commands are strictly one at a time: the next header is offered only after the previous response has fully drained.

Top module: `qfr_read_seq`

## Requirements
- R1: A request is refused without sending any command when the address is not word aligned (bits [1:0] nonzero), the word count is 0 or above 1024, or the chip index is above 3. On a refusal, done pulses in the cycle after start, err is 1 and err_code is 0x7F0.
- R2: An accepted request issues commands in a fixed order, each with its command code in header bits [10:0]. The order is claim (0x32), then chip select (0x34), then read (0x3A), then release (0x33).
- R3: Every command header carries the argument count in bits [22:12] and a transaction ID in bits [27:24]. Bits [31:28], [23] and [11] are zero. The ID starts at 0 after reset and advances by one after each completed response.
- R4: The chip-select argument carries the chip index in bits [31:28] with all other bits zero. The read arguments are the address first and then the word count.
- R5: Only one command is outstanding at a time. While a response is awaited, rsp_ready is high and cmd_valid is low; the next command starts only after the response end-of-packet beat.
- R6: After a read response header that is accepted, every following response word appears on rd_data with rd_valid, in order and unchanged.
- R7: A response code of 0x81 (access already held) counts as success, and the sequence continues.
- R8: A response code other than 0 and 0x81 records err=1 and err_code equal to that code, and no read data is forwarded. A failure after the claim still issues the release command. A failed claim ends the transaction with no further command.
- R9: A response header whose ID (bits [27:24]) differs from the ID of the command it answers is a failure with err_code 0x7F1, and it takes the same abort path as R8.
- R10: done is a one-cycle pulse at the end of each request. busy is high from acceptance until the cycle done pulses. err and err_code keep the first failure of a transaction until the next accepted start and are 0 after a clean transaction.
- R11: A start strobe while busy is high has no effect on the running transaction or on later commands.
- R12: A command word offered without ready is held unchanged until accepted. cmd_sop marks the header and cmd_eop marks the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled when idle |
| addr_i | input | 32 | Flash byte address |
| count_i | input | 11 | Words to read |
| cs_i | input | 3 | Flash chip index |
| cmd_ready_i | input | 1 | Mailbox accepts a command word |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_data_o | output | 32 | Command word |
| cmd_sop_o | output | 1 | First word of a command |
| cmd_eop_o | output | 1 | Last word of a command |
| rsp_valid_i | input | 1 | Response word valid |
| rsp_data_i | input | 32 | Response word |
| rsp_sop_i | input | 1 | First word of a response |
| rsp_eop_i | input | 1 | Last word of a response |
| rsp_ready_o | output | 1 | Block accepts a response word |
| rd_valid_o | output | 1 | Read data word valid |
| rd_data_o | output | 32 | Read data word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Transaction failed |
| err_code_o | output | 11 | Captured failure code |

## Verification
The hardest situations to reach are the abort paths, because they depend entirely on what the far side answers. These are a failure or ID mismatch in the middle of the sequence, which must still be followed by a release command, and an already-held answer that must not stop the read. The bench therefore plays the mailbox responder itself. It chooses, per transaction, which command is answered with which code or with a corrupted ID, and it predicts from the rules which command must come next. Random backpressure on the command port, a maximum 1024-word read and a stray start pulse during a busy transaction are mixed in.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {PH_OPEN, PH_SEL, PH_READ, PH_CLOSE} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_e;

    localparam logic [10:0] OP_OPEN    = 11'h032;
    localparam logic [10:0] OP_SEL     = 11'h034;
    localparam logic [10:0] OP_READ    = 11'h03A;
    localparam logic [10:0] OP_CLOSE   = 11'h033;
    localparam logic [10:0] RC_OK      = 11'h000;
    localparam logic [10:0] RC_ALREADY = 11'h081;
    localparam logic [10:0] RC_REJECT  = 11'h7F0;
    localparam logic [10:0] RC_BADID   = 11'h7F1;

    typedef struct packed {
        logic [3:0]  rsv_hi;
        logic [3:0]  id;
        logic        rsv_mid;
        logic [10:0] len;
        logic        rsv_lo;
        logic [10:0] code;
    } hdr_t;

    typedef struct packed {
        logic        fail;
        logic [10:0] code;
    } verdict_t;

    function automatic logic [10:0] phase_op(phase_e p);
        case (p)
            PH_OPEN: return OP_OPEN;
            PH_SEL:  return OP_SEL;
            PH_READ: return OP_READ;
            default: return OP_CLOSE;
        endcase
    endfunction

    function automatic logic [1:0] phase_nargs(phase_e p);
        case (p)
            PH_SEL:  return 2'd1;
            PH_READ: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mk_hdr(logic [3:0] id, logic [10:0] len,
                                                 logic [10:0] code);
        hdr_t h;
        h      = '0;
        h.id   = id;
        h.len  = len;
        h.code = code;
        return h;
    endfunction

endpackage

// File: rtl/qfr_req_check.sv
module qfr_req_check #(
    parameter int MAX_WORDS = 1024,
    parameter int NUM_CS    = 4,
    parameter int CNT_W     = 11,
    parameter int CS_W      = 3
) (
    input  logic [1:0]       addr_lsb_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CS_W-1:0]  cs_i,
    output logic             ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WORDS);
    localparam logic [CS_W-1:0]  CS_LIM  = CS_W'(NUM_CS - 1);

    always_comb begin
        ok_o = (addr_lsb_i == 2'b00)
            && (count_i != '0)
            && (count_i <= CNT_MAX)
            && (cs_i <= CS_LIM);
    end
endmodule

// File: rtl/qfr_cmd_emit.sv
module qfr_cmd_emit
    import qfr_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int CS_W  = 3
) (
    input  phase_e            phase_i,
    input  logic [1:0]        widx_i,
    input  logic [3:0]        id_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CS_W-1:0]   cs_i,
    output logic [WORD_W-1:0] data_o,
    output logic              last_o
);
    localparam int CS_SHIFT = WORD_W - 4;

    always_comb begin
        data_o = '0;
        if (widx_i == 2'd0) begin
            data_o = mk_hdr(id_i, 11'(phase_nargs(phase_i)), phase_op(phase_i));
        end else begin
            case (phase_i)
                PH_SEL:  data_o = WORD_W'(cs_i) << CS_SHIFT;
                PH_READ: data_o = (widx_i == 2'd1) ? addr_i : WORD_W'(count_i);
                default: data_o = '0;
            endcase
        end
        last_o = (widx_i == phase_nargs(phase_i));
    end
endmodule

// File: rtl/qfr_rsp_eval.sv
module qfr_rsp_eval
    import qfr_pkg::*;
(
    input  logic [3:0]  rsp_id_i,
    input  logic [10:0] rsp_code_i,
    input  logic [3:0]  exp_id_i,
    output verdict_t    verdict_o
);
    logic id_bad;

    always_comb begin
        id_bad = (rsp_id_i != exp_id_i);
        verdict_o.fail = id_bad || ((rsp_code_i != RC_OK) && (rsp_code_i != RC_ALREADY));
        verdict_o.code = id_bad ? RC_BADID : rsp_code_i;
    end
endmodule

// File: rtl/qfr_read_seq.sv
module qfr_read_seq
    import qfr_pkg::*;
#(
    parameter int MAX_WORDS = 1024,
    parameter int NUM_CS    = 4,
    parameter int CS_W      = 3,
    parameter int CNT_W     = $clog2(MAX_WORDS) + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [31:0]       addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CS_W-1:0]   cs_i,
    input  logic              cmd_ready_i,
    output logic              cmd_valid_o,
    output logic [31:0]       cmd_data_o,
    output logic              cmd_sop_o,
    output logic              cmd_eop_o,
    input  logic              rsp_valid_i,
    input  logic [31:0]       rsp_data_i,
    input  logic              rsp_sop_i,
    input  logic              rsp_eop_i,
    output logic              rsp_ready_o,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [10:0]       err_code_o
);
    state_e             state_q;
    phase_e             phase_q;
    logic [1:0]         widx_q;
    logic [3:0]         id_q;
    logic [WORD_W-1:0]  addr_q;
    logic [CNT_W-1:0]   count_q;
    logic [CS_W-1:0]    cs_q;
    logic               hdr_seen_q, hdr_ok_q, fail_q;
    logic               err_q, done_q;
    logic [10:0]        code_q;

    logic               req_ok, emit_last, is_hdr, cur_fail;
    logic [WORD_W-1:0]  emit_data;
    verdict_t           verdict;

    qfr_req_check #(
        .MAX_WORDS(MAX_WORDS), .NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)
    ) u_check (
        .addr_lsb_i(addr_i[1:0]),
        .count_i   (count_i),
        .cs_i      (cs_i),
        .ok_o      (req_ok)
    );

    qfr_cmd_emit #(.CNT_W(CNT_W), .CS_W(CS_W)) u_emit (
        .phase_i(phase_q),
        .widx_i (widx_q),
        .id_i   (id_q),
        .addr_i (addr_q),
        .count_i(count_q),
        .cs_i   (cs_q),
        .data_o (emit_data),
        .last_o (emit_last)
    );

    qfr_rsp_eval u_eval (
        .rsp_id_i  (rsp_data_i[27:24]),
        .rsp_code_i(rsp_data_i[10:0]),
        .exp_id_i  (id_q),
        .verdict_o (verdict)
    );

    always_comb begin
        is_hdr      = !hdr_seen_q || rsp_sop_i;
        cur_fail    = is_hdr ? verdict.fail : fail_q;
        cmd_valid_o = (state_q == ST_SEND);
        cmd_data_o  = emit_data;
        cmd_sop_o   = (state_q == ST_SEND) && (widx_q == 2'd0);
        cmd_eop_o   = (state_q == ST_SEND) && emit_last;
        rsp_ready_o = (state_q == ST_WAIT);
        rd_valid_o  = (state_q == ST_WAIT) && (phase_q == PH_READ) && !is_hdr
                   && hdr_ok_q && rsp_valid_i;
        rd_data_o   = rsp_data_i;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        err_o       = err_q;
        err_code_o  = code_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_OPEN;
            widx_q     <= '0;
            id_q       <= '0;
            addr_q     <= '0;
            count_q    <= '0;
            cs_q       <= '0;
            hdr_seen_q <= 1'b0;
            hdr_ok_q   <= 1'b0;
            fail_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (req_ok) begin
                            addr_q  <= addr_i;
                            count_q <= count_i;
                            cs_q    <= cs_i;
                            err_q   <= 1'b0;
                            code_q  <= '0;
                            phase_q <= PH_OPEN;
                            widx_q  <= '0;
                            state_q <= ST_SEND;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            code_q <= RC_REJECT;
                        end
                    end
                end
                ST_SEND: begin
                    if (cmd_ready_i) begin
                        if (emit_last) begin
                            state_q    <= ST_WAIT;
                            hdr_seen_q <= 1'b0;
                            hdr_ok_q   <= 1'b0;
                            fail_q     <= 1'b0;
                        end else begin
                            widx_q <= widx_q + 2'd1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        if (is_hdr) begin
                            hdr_seen_q <= 1'b1;
                            hdr_ok_q   <= !verdict.fail;
                            fail_q     <= verdict.fail;
                            if (verdict.fail && !err_q) begin
                                err_q  <= 1'b1;
                                code_q <= verdict.code;
                            end
                        end
                        if (rsp_eop_i) begin
                            id_q   <= id_q + 4'd1;
                            widx_q <= '0;
                            if (cur_fail) begin
                                if (phase_q == PH_OPEN || phase_q == PH_CLOSE) begin
                                    state_q <= ST_IDLE;
                                    done_q  <= 1'b1;
                                end else begin
                                    phase_q <= PH_CLOSE;
                                    state_q <= ST_SEND;
                                end
                            end else if (phase_q == PH_CLOSE) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                phase_q <= phase_e'(phase_q + 2'd1);
                                state_q <= ST_SEND;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qfr_read_seq_chk.sv
module qfr_read_seq_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        cmd_valid_o,
    input logic        cmd_ready_i,
    input logic [31:0] cmd_data_o,
    input logic        cmd_sop_o,
    input logic        cmd_eop_o,
    input logic        rsp_valid_i,
    input logic        rsp_ready_o,
    input logic        rd_valid_o,
    input logic        busy_o,
    input logic        done_o
);
    assert_hold_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o) && $stable(cmd_eop_o));

    assert_opcode_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid_o && cmd_sop_o |-> (cmd_data_o[10:0] == 11'h032) || (cmd_data_o[10:0] == 11'h034)
                                  || (cmd_data_o[10:0] == 11'h03A) || (cmd_data_o[10:0] == 11'h033));

    assert_hdr_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid_o && cmd_sop_o |-> cmd_data_o[31:28] == 4'h0 && !cmd_data_o[23] && !cmd_data_o[11]);

    assert_one_outstanding_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(cmd_valid_o && rsp_ready_o));

    assert_rd_gated_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |-> rsp_valid_i && rsp_ready_o);

    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_busy_end_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);
endmodule

bind qfr_read_seq qfr_read_seq_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_data_o (cmd_data_o),
    .cmd_sop_o  (cmd_sop_o),
    .cmd_eop_o  (cmd_eop_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_ready_o(rsp_ready_o),
    .rd_valid_o (rd_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_qfr_read_seq.sv
module test_qfr_read_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] addr;
    logic [10:0] count;
    logic [2:0]  cs_in;
    logic        cmd_ready, cmd_valid, cmd_sop, cmd_eop;
    logic [31:0] cmd_data;
    logic        rsp_valid, rsp_sop, rsp_eop, rsp_ready;
    logic [31:0] rsp_data;
    logic        rd_valid, busy, done, err;
    logic [31:0] rd_data;
    logic [10:0] err_code;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_id = 4'd0;
    logic [31:0] rq[$];
    logic [31:0] cw[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qfr_read_seq i_qfr_read_seq (
        .clk_i(clk), .rst_i(rst), .start_i(start), .addr_i(addr), .count_i(count),
        .cs_i(cs_in), .cmd_ready_i(cmd_ready), .cmd_valid_o(cmd_valid),
        .cmd_data_o(cmd_data), .cmd_sop_o(cmd_sop), .cmd_eop_o(cmd_eop),
        .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_sop_i(rsp_sop),
        .rsp_eop_i(rsp_eop), .rsp_ready_o(rsp_ready), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
        .err_code_o(err_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] f_op(int ph);
        case (ph)
            0: return 11'h032;
            1: return 11'h034;
            2: return 11'h03A;
            default: return 11'h033;
        endcase
    endfunction

    function automatic int f_nargs(int ph);
        return (ph == 1) ? 1 : (ph == 2) ? 2 : 0;
    endfunction

    function automatic logic [31:0] f_word(logic [31:0] a, int i);
        return a ^ (32'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    // Plays the mailbox: answers each command, predicts the next one.
    task automatic run_txn(input logic [31:0] a, input int n, input int cs,
                           input int fail_ph, input logic [10:0] fcode,
                           input bit bad_id, input bit poke);
        int ph = 0;
        bit e_err = 0;
        logic [10:0] e_code = '0;
        int rd_cnt = 0;
        int e_rd = 0;
        bit saw_done = 0;
        bit rfirst = 1;
        rq.delete(); cw.delete();
        @(negedge clk);
        start = 1; addr = a; count = 11'(n); cs_in = 3'(cs);
        @(negedge clk);
        start = 0;
        for (int cyc = 0; cyc < 20000 && !saw_done; cyc++) begin
            cmd_ready = ($urandom % 4) != 0;
            if (rq.size() > 0) begin
                rsp_valid = 1; rsp_data = rq[0]; rsp_sop = rfirst; rsp_eop = (rq.size() == 1);
            end else begin
                rsp_valid = 0; rsp_sop = 0; rsp_eop = 0;
            end
            if (poke && cyc == 3) begin
                start = 1; addr = a + 4; count = 11'(n % 1024 + 1); cs_in = 3'(cs ^ 1);
            end else if (poke && cyc == 4) begin
                start = 0;
            end
            #1;
            if (cyc == 0) check(busy == 1, "R10", "busy after accept", busy, 1);
            if (cmd_valid && cmd_ready) begin
                cw.push_back(cmd_data);
                if (cmd_eop) begin
                    logic [31:0] h;
                    logic [10:0] rc;
                    logic [3:0]  rid;
                    bit fl;
                    bit okc;
                    h = cw[0];
                    okc = (ph < 4) && (h[10:0] == f_op(ph));
                    check(okc, "R2", "command code", h[10:0], f_op(ph));
                    check(h[22:12] == 11'(f_nargs(ph)) && h[27:24] == exp_id && h[31:28] == 0
                          && !h[23] && !h[11] && cw.size() == f_nargs(ph) + 1,
                          "R3", "header fields", h, {exp_id, 1'b0, 11'(f_nargs(ph)), 1'b0, f_op(ph)});
                    if (ph == 1)
                        check(cw[1] == {4'(cs), 28'h0}, "R4", "chip select arg", cw[1], {4'(cs), 28'h0});
                    if (ph == 2)
                        check(cw[1] == a && cw[2] == 32'(n), "R4", "read args", cw[1], a);
                    rc  = (ph == fail_ph) ? fcode : 11'h000;
                    rid = exp_id ^ ((bad_id && ph == fail_ph) ? 4'd1 : 4'd0);
                    fl  = (bad_id && ph == fail_ph) || (rc != 11'h000 && rc != 11'h081);
                    rq.push_back({4'h0, rid, 1'b0, (ph == 2) ? 11'(n) : 11'h0, 1'b0, rc});
                    if (ph == 2 && !fl) begin
                        for (int i = 0; i < n; i++) rq.push_back(f_word(a, i));
                        e_rd = n;
                    end
                    rfirst = 1;
                    if (fl && !e_err) begin
                        e_err = 1; e_code = (bad_id && ph == fail_ph) ? 11'h7F1 : rc;
                    end
                    if (fl) ph = (ph == 0 || ph == 3) ? 4 : 3;
                    else    ph = (ph == 3) ? 4 : ph + 1;
                    exp_id = exp_id + 4'd1;
                    cw.delete();
                end
            end
            if (rsp_valid && rsp_ready) begin
                void'(rq.pop_front());
                rfirst = 0;
            end
            if (rd_valid) begin
                check(rd_data == f_word(a, rd_cnt), "R6", "read word", rd_data, f_word(a, rd_cnt));
                rd_cnt++;
            end
            if (done) saw_done = 1;
            @(negedge clk);
        end
        check(saw_done, "R10", "done seen", saw_done, 1);
        check(ph == 4, "R8", "sequence completed as predicted", ph, 4);
        check(rd_cnt == e_rd, "R6", "read word count", rd_cnt, e_rd);
        check(err == e_err && err_code == e_code, "R8", "err/err_code", {err, err_code}, {e_err, e_code});
        cmd_ready = 1; rsp_valid = 0; rsp_sop = 0; rsp_eop = 0;
        #1;
        check(!done && !busy, "R10", "done is one pulse", {done, busy}, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check(!cmd_valid, "R11", "no command after end", cmd_valid, 0);
        end
        check(err == e_err && err_code == e_code, "R10", "error held", {err, err_code}, {e_err, e_code});
    endtask

    task automatic run_reject(input logic [31:0] a, input int n, input int cs);
        @(negedge clk);
        cmd_ready = 1; start = 1; addr = a; count = 11'(n); cs_in = 3'(cs);
        @(negedge clk);
        start = 0;
        #1;
        check(done && err && err_code == 11'h7F0 && !busy, "R1", "refusal", {done, err, err_code}, {2'b11, 11'h7F0});
        check(!cmd_valid, "R1", "no command on refusal", cmd_valid, 0);
        @(negedge clk); #1;
        check(!done && !cmd_valid, "R1", "refusal quiet", {done, cmd_valid}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] codes [5] = '{11'h081, 11'h080, 11'h009, 11'h004, 11'h3FF};
        void'($urandom(32'd24681));
        rst = 1; start = 0; addr = 0; count = 0; cs_in = 0;
        cmd_ready = 0; rsp_valid = 0; rsp_data = 0; rsp_sop = 0; rsp_eop = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!cmd_valid && !rsp_ready && !busy && !done && !err && err_code == 0 && !rd_valid,
              "R10", "reset state", {cmd_valid, rsp_ready, busy, done, err}, 0);
        @(negedge clk);
        rst = 0;

        run_txn(32'h0000_1000, 4, 0, 9, 11'h0, 0, 0);     // clean, R2 R3 R4 R6
        run_txn(32'h00FF_0000, 1024, 3, 9, 11'h0, 0, 0);  // max count
        run_txn(32'h0000_0004, 1, 2, 0, 11'h081, 0, 0);   // R7 already open
        run_txn(32'h0000_0008, 3, 1, 0, 11'h080, 0, 0);   // R8 claim fails, no release
        run_txn(32'h0000_0010, 3, 1, 1, 11'h009, 0, 0);   // R8 select fails, release
        run_txn(32'h0000_0020, 5, 0, 2, 11'h00B, 0, 0);   // R8 read fails, no data
        run_txn(32'h0000_0040, 2, 0, 3, 11'h3FF, 0, 0);   // R8 release fails
        run_txn(32'h0000_0080, 6, 2, 2, 11'h000, 1, 0);   // R9 id mismatch on read
        run_txn(32'h0000_0100, 8, 1, 9, 11'h0, 0, 1);     // R11 start while busy
        run_reject(32'h0000_0002, 4, 0);                  // R1 unaligned
        run_reject(32'h0000_0000, 0, 0);                  // R1 zero count
        run_reject(32'h0000_0000, 1025, 0);               // R1 too many
        run_reject(32'h0000_0000, 4, 4);                  // R1 chip index
        run_txn(32'h0000_0200, 2, 0, 9, 11'h0, 0, 0);     // R10 err cleared after refusal

        for (int t = 0; t < 30; t++) begin
            run_txn($urandom & 32'hFFFF_FFFC, 1 + $urandom % 24, $urandom % 4,
                    $urandom % 6, codes[$urandom % 5], ($urandom % 8) == 0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule